// File: doc/BRIEF.md
# Asynchronous Parallel-Bus Burst Read Controller

This controller sits on the host side of an asynchronous parallel peripheral bus and runs read cycles on it. The bus has an active-low select, an active-low read strobe, a word address and a 32-bit data path. A 16-bit mode is also available, in which only the low half of the data path carries data. A synchronous client issues one request that gives a start address, a word count and a width mode. The controller then pulls both strobes low and keeps them low for the whole burst. It advances only the low address field from one word to the next and captures one word per address step. Each captured word is returned with a one-cycle valid pulse.

All bus timing is set in nanoseconds. At elaboration the limits are converted to clock counts, rounding up against a clock-period parameter. With the defaults (8 ns clock, 30 ns data-valid time, 32 ns minimum strobe-low time, 13 ns minimum strobe-high time, 45 ns minimum cycle), each word holds its address for 4 clocks. After a burst the strobes stay high for at least 2 clocks before the next burst can start.

Top module: `pio_burst_reader`

## Requirements
- R1: While `rst_n` is low, `bus_cs_n` and `bus_rd_n` are 1, `req_ready` is 1, and `rd_valid` and `rd_done` are 0.
- R2: A request is taken on the rising edge at which `req_valid` and `req_ready` are both 1. From that edge both strobes are 0 and `bus_addr` shows the first word address.
- R3: Word k (counting from 0) is captured 4·(k+1) clocks after the accepting edge. `rd_valid` is 1 for exactly that one cycle and `rd_data` holds the word.
- R4: Within a burst, `bus_addr[6:4]` keeps the value taken from `req_addr[6:4]`.
- R5: The low field `bus_addr[3:0]` wraps modulo 16. In 32-bit mode (`req_half`=0), bit 0 of the field is forced to 0 and the field steps by 2 per word. In 16-bit mode (`req_half`=1), the field starts at `req_addr[3:0]` and steps by 1.
- R6: The word count is `req_len`, with two adjustments: a value of 0 counts as 1, and the count is limited to 8 in 32-bit mode and 16 in 16-bit mode.
- R7: In 16-bit mode, `rd_data[31:16]` is 0 whatever the bus drives there.
- R8: `rd_done` is 1 for one cycle, exactly one clock after the valid pulse of the last word.
- R9: Both strobes return to 1 on the edge that captures the last word. `req_ready` stays 0 from the accepting edge until 2 clocks after that capture edge, so the strobes stay high for at least 2 clocks between bursts.
- R10: A request held on `req_valid` while the controller is busy has no effect until `req_ready` returns. It is then taken on the next edge.
- R11: The word hold time is max(⌈tDV/tCLK⌉, ⌈tLOW/tCLK⌉) clocks. The recovery time is max(⌈tHIGH/tCLK⌉, ⌈tCYC/tCLK⌉ − hold) clocks. With the default parameters these are 4 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 7 | Start word address (upper field 6:4, low field 3:0) |
| req_len | input | 5 | Requested word count |
| req_half | input | 1 | 1 selects 16-bit mode, 0 selects 32-bit mode |
| rd_valid | output | 1 | One-cycle pulse with each captured word |
| rd_data | output | 32 | Captured word |
| rd_done | output | 1 | One-cycle pulse after the last word |
| bus_cs_n | output | 1 | Active-low select |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_addr | output | 7 | Word address on the bus |
| bus_data_i | input | 32 | Data from the peripheral |

## Verification
Cycles are counted from the edge that accepts a request, which is cycle 0. Word k is due in cycle 4(k+1) and the done pulse in cycle 4n+1. Both strobes are high from cycle 4n, and ready comes back in cycle 4n+2. The bench samples every cycle of every burst on the falling clock edge. In each cycle it compares valid, done, ready, the strobes and the address with values it derives from these formulas, so an event that comes one clock early or late shows up as a mismatch. The bench models the peripheral as a function of the bus address, which lets it compute each expected word from its own address sequence.

// File: rtl/pio_rd_pkg.sv
package pio_rd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BEAT  = 2'd1,
      ST_RECOV = 2'd2
   } pio_state_e;

   // Nanoseconds to whole clock cycles, rounded up.
   function automatic int ns2cyc(input int ns, input int period_ns);
      return (ns + period_ns - 1) / period_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pio_phase_timer.sv
module pio_phase_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (load)       cnt_q <= load_val;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   a_r11_timer_no_underflow : assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != 0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pio_addr_stepper.sv
module pio_addr_stepper #(
   parameter int ADDR_W = 7,
   parameter int LOW_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              half,
   input  logic              step,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int HI_W = ADDR_W - LOW_W;

   logic [HI_W-1:0]  hi_q;
   logic [LOW_W-1:0] lo_q;
   logic             half_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         half_q <= 1'b0;
      end else if (load) begin
         hi_q   <= load_addr[ADDR_W-1:LOW_W];
         lo_q   <= half ? load_addr[LOW_W-1:0]
                        : {load_addr[LOW_W-1:1], 1'b0};
         half_q <= half;
      end else if (step) begin
         lo_q   <= lo_q + (half_q ? LOW_W'(1) : LOW_W'(2));
      end
   end

   assign addr_o = {hi_q, lo_q};

   a_r5_word_aligned : assert property (@(posedge clk) disable iff (!rst_n)
      (!half_q) |-> (lo_q[0] == 1'b0));
endmodule

// File: rtl/pio_lane_capture.sv
module pio_lane_capture #(
   parameter int DATA_W = 32,
   parameter int HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              half,
   input  logic [DATA_W-1:0] bus_d,
   output logic [DATA_W-1:0] data_o
);
   localparam int NLANE = DATA_W / HALF_W;

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      logic [HALF_W-1:0] lane_q;
      if (g == 0) begin : g_low
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       lane_q <= '0;
            else if (capture) lane_q <= bus_d[HALF_W-1:0];
         end
      end else begin : g_high
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       lane_q <= '0;
            else if (capture) lane_q <= half ? '0 : bus_d[g*HALF_W +: HALF_W];
         end
      end
      assign data_o[g*HALF_W +: HALF_W] = lane_q;
   end

   a_r7_upper_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (capture && half) |=> (data_o[DATA_W-1:HALF_W] == '0));
endmodule

// File: rtl/pio_burst_reader.sv
module pio_burst_reader
   import pio_rd_pkg::*;
#(
   parameter int CLK_NS          = 8,
   parameter int T_DATA_VALID_NS = 30,
   parameter int T_STRB_LOW_NS   = 32,
   parameter int T_STRB_HIGH_NS  = 13,
   parameter int T_CYCLE_NS      = 45,
   parameter int ADDR_W          = 7,
   parameter int LOW_W           = 4,
   parameter int DATA_W          = 32,
   parameter int HALF_W          = 16,
   parameter int MAX_WORDS32     = 8,
   parameter int MAX_WORDS16     = 16,
   parameter int LEN_W           = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_half,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_done,
   output logic              bus_cs_n,
   output logic              bus_rd_n,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data_i
);
   localparam int BEAT_C  = imax(imax(ns2cyc(T_DATA_VALID_NS, CLK_NS),
                                      ns2cyc(T_STRB_LOW_NS, CLK_NS)), 1);
   localparam int RECOV_C = imax(imax(ns2cyc(T_STRB_HIGH_NS, CLK_NS),
                                      ns2cyc(T_CYCLE_NS, CLK_NS) - BEAT_C), 1);
   localparam int CNT_W   = $clog2(imax(BEAT_C, RECOV_C) + 1);

   if (DATA_W % HALF_W != 0) begin : g_chk_lanes
      $error("DATA_W must be a multiple of HALF_W");
   end
   if (MAX_WORDS16 >= (1 << LEN_W) || MAX_WORDS32 >= (1 << LEN_W)) begin : g_chk_len
      $error("LEN_W too narrow for the burst limits");
   end
   if (MAX_WORDS16 > (1 << LOW_W) || LOW_W >= ADDR_W) begin : g_chk_addr
      $error("low address field cannot hold a full burst");
   end

   pio_state_e        state_q;
   logic              strobe_q, half_q, last_q;
   logic [LEN_W-1:0]  left_q, max_len, len_eff;
   logic              accept, expired, beat_end, final_beat;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;

   assign req_ready  = (state_q == ST_IDLE);
   assign accept     = req_valid && req_ready;
   assign beat_end   = (state_q == ST_BEAT) && expired;
   assign final_beat = beat_end && (left_q == LEN_W'(1));

   always_comb begin
      max_len = req_half ? LEN_W'(MAX_WORDS16) : LEN_W'(MAX_WORDS32);
      if (req_len == '0)          len_eff = LEN_W'(1);
      else if (req_len > max_len) len_eff = max_len;
      else                        len_eff = req_len;
   end

   always_comb begin
      tmr_load = accept || beat_end;
      tmr_val  = final_beat ? CNT_W'(RECOV_C - 1) : CNT_W'(BEAT_C - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         strobe_q <= 1'b0;
         left_q   <= '0;
         half_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               state_q  <= ST_BEAT;
               strobe_q <= 1'b1;
               left_q   <= len_eff;
               half_q   <= req_half;
            end
            ST_BEAT: if (expired) begin
               left_q <= left_q - 1'b1;
               if (left_q == LEN_W'(1)) begin
                  state_q  <= ST_RECOV;
                  strobe_q <= 1'b0;
               end
            end
            ST_RECOV: if (expired) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         last_q   <= 1'b0;
         rd_done  <= 1'b0;
      end else begin
         rd_valid <= beat_end;
         last_q   <= final_beat;
         rd_done  <= rd_valid && last_q;
      end
   end

   assign bus_cs_n = ~strobe_q;
   assign bus_rd_n = ~strobe_q;

   pio_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(expired)
   );

   pio_addr_stepper #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_addr(req_addr), .half(req_half),
      .step(beat_end && !final_beat), .addr_o(bus_addr)
   );

   pio_lane_capture #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .capture(beat_end), .half(half_q),
      .bus_d(bus_data_i), .data_o(rd_data)
   );

   // Checker state: address hold age, strobe-high age, words seen in a burst.
   logic [CNT_W-1:0] hold_cnt, high_cnt;
   logic [ADDR_W-1:0] addr_prev;
   logic              cs_prev;
   logic [LEN_W:0]    seen_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt  <= '0;
         high_cnt  <= CNT_W'(RECOV_C);
         addr_prev <= '0;
         cs_prev   <= 1'b1;
         seen_cnt  <= '0;
      end else begin
         addr_prev <= bus_addr;
         cs_prev   <= bus_cs_n;
         if (bus_cs_n)                             hold_cnt <= '0;
         else if (cs_prev || bus_addr != addr_prev) hold_cnt <= CNT_W'(1);
         else if (hold_cnt < CNT_W'(BEAT_C))        hold_cnt <= hold_cnt + 1'b1;
         if (!bus_cs_n)                            high_cnt <= '0;
         else if (high_cnt < CNT_W'(RECOV_C))       high_cnt <= high_cnt + 1'b1;
         if (accept)        seen_cnt <= '0;
         else if (rd_valid) seen_cnt <= seen_cnt + 1'b1;
      end
   end

   a_r2_accept_drives_strobes : assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (!bus_cs_n && !bus_rd_n));
   a_r9_not_ready_while_low : assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n) |-> !req_ready);
   a_r3_address_held : assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (hold_cnt >= CNT_W'(BEAT_C)));
   a_r4_upper_fixed : assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && !cs_prev) |-> (bus_addr[ADDR_W-1:LOW_W] == addr_prev[ADDR_W-1:LOW_W]));
   a_r5_low_step : assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && !cs_prev && bus_addr != addr_prev) |->
      (LOW_W'(bus_addr[LOW_W-1:0] - addr_prev[LOW_W-1:0]) == (half_q ? LOW_W'(1) : LOW_W'(2))));
   a_r6_burst_cap : assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (int'(seen_cnt) < (half_q ? MAX_WORDS16 : MAX_WORDS32)));
   a_r8_done_after_valid : assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> $past(rd_valid));
   a_r9_recovery_gap : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_cs_n) |-> (high_cnt >= CNT_W'(RECOV_C)));
endmodule

// File: tb/pio_burst_reader_tb_top.sv
module pio_burst_reader_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [6:0]  req_addr = '0;
   logic [4:0]  req_len = '0;
   logic        req_half = 1'b0;
   logic        rd_valid, rd_done, bus_cs_n, bus_rd_n;
   logic [31:0] rd_data, bus_data;
   logic [6:0]  bus_addr;
   int          checks = 0;
   int          errors = 0;
   bit          finished = 1'b0;

   always #4 clk = ~clk;

   function automatic logic [31:0] periph(input logic [6:0] a);
      return {8'hC3, 1'b0, a, 8'h96 ^ {1'b0, a}, 1'b0, ~a};
   endfunction

   assign bus_data = (!bus_cs_n && !bus_rd_n) ? periph(bus_addr) : 32'hDEAD_BEEF;

   pio_burst_reader dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .req_half(req_half),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_done(rd_done),
      .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_addr(bus_addr), .bus_data_i(bus_data)
   );

   function automatic logic [6:0] exp_addr(input logic [6:0] a, input logic h, input int k);
      logic [3:0] lo;
      lo = h ? a[3:0] : {a[3:1], 1'b0};
      lo = lo + (h ? 4'(k) : 4'(2 * k));
      return {a[6:4], lo};
   endfunction

   function automatic logic [31:0] exp_word(input logic [6:0] a, input logic h, input int k);
      logic [31:0] w;
      w = periph(exp_addr(a, h, k));
      if (h) w[31:16] = '0;
      return w;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Issue one burst and check every cycle until ready returns (cycle 4n+2).
   task automatic run_burst(input logic [6:0] a, input logic [4:0] len, input logic h,
                            input int n, input bit keep);
      while (!req_ready) @(negedge clk);
      req_addr = a; req_len = len; req_half = h; req_valid = 1'b1;
      @(posedge clk);
      for (int c = 0; c <= 4 * n + 2; c++) begin
         @(negedge clk);
         if (c == 0 && !keep) req_valid = 1'b0;
         check("R3 valid timing (R11)", 32'(rd_valid),
               32'((c % 4 == 0) && c >= 4 && (c / 4) <= n));
         if ((c % 4 == 0) && c >= 4 && (c / 4) <= n)
            check("R3/R7 word data", rd_data, exp_word(a, h, c / 4 - 1));
         check("R8 done pulse", 32'(rd_done), 32'(c == 4 * n + 1));
         check("R2/R9 select level", 32'(bus_cs_n), 32'(c >= 4 * n));
         check("R2/R9 read strobe level", 32'(bus_rd_n), 32'(c >= 4 * n));
         if (c < 4 * n)
            check("R4/R5/R6 bus address", 32'(bus_addr), 32'(exp_addr(a, h, c / 4)));
         check("R9 ready level", 32'(req_ready), 32'(c >= 4 * n + 2));
      end
   endtask

   // {addr[6:0], len[4:0], half, expected words[4:0]}
   localparam logic [17:0] VEC [8] = '{
      {7'h20, 5'd1,  1'b0, 5'd1},
      {7'h45, 5'd8,  1'b0, 5'd8},
      {7'h60, 5'd16, 1'b1, 5'd16},
      {7'h13, 5'd3,  1'b1, 5'd3},
      {7'h0A, 5'd12, 1'b0, 5'd8},
      {7'h7F, 5'd20, 1'b1, 5'd16},
      {7'h01, 5'd0,  1'b0, 5'd1},
      {7'h5E, 5'd0,  1'b1, 5'd1}
   };

   initial begin
      @(negedge clk);
      check("R1 reset select", 32'(bus_cs_n), 32'd1);
      check("R1 reset strobe", 32'(bus_rd_n), 32'd1);
      check("R1 reset ready", 32'(req_ready), 32'd1);
      check("R1 reset valid", 32'(rd_valid), 32'd0);
      check("R1 reset done", 32'(rd_done), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 8; i++) begin
         logic [17:0] v;
         v = VEC[i];
         run_burst(v[17:11], v[10:6], v[5], int'(v[4:0]), 1'b0);
      end

      // R10: a second request held high while busy is taken only once ready returns.
      run_burst(7'h31, 5'd2, 1'b0, 2, 1'b1);
      req_addr = 7'h55; req_len = 5'd1; req_half = 1'b1;
      @(negedge clk);
      check("R10 held request taken after recovery", 32'(bus_cs_n), 32'd0);
      check("R10 held request address", 32'(bus_addr), 32'h55);
      check("R10 busy again", 32'(req_ready), 32'd0);
      req_valid = 1'b0;
      while (!req_ready) @(negedge clk);

      // R1: reset in the middle of a burst releases the strobes at once.
      req_addr = 7'h22; req_len = 5'd8; req_half = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (5) @(negedge clk);
      check("R1 strobes low before mid-burst reset", 32'(bus_cs_n), 32'd0);
      rst_n = 1'b0;
      #1;
      check("R1 mid-burst reset select", 32'(bus_cs_n), 32'd1);
      check("R1 mid-burst reset ready", 32'(req_ready), 32'd1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule